// File: doc/BRIEF.md
# I2C Register-Access Target with Wide Pointer

This block is the target side of an I2C link into a register bank. It recovers bus events from two-flop-synchronized SCL and SDA, answers a 7-bit device address and turns host traffic into single-cycle read and write strobes on a synchronous register port. The address's five upper bits are a build parameter. The two lower bits come from strap pins sampled while reset is held. For a programmable number of clock cycles after reset it ignores the bus entirely.

A write transaction carries a register pointer sent as three bytes, most significant first. Next comes a control byte: its bit 0 enables pointer auto-increment and its bits 2:1 select the access width. Any bytes after that are data, and each one is written to the register at the current pointer. A read transaction returns bytes starting at the pointer left by earlier traffic. A repeated start lets the host set the pointer and then read back without a stop in between.

Top module: `i2c_ptr_target`

## Requirements
- R1: A falling SDA while SCL is high (start) puts the block back into address reception from any state, with SDA released. A rising SDA while SCL is high (stop) returns it to idle. The target changes its SDA drive only while SCL is low.
- R2: The device address is {BASE_ADDR[4:0], strap[1:0]}, sent MSB first, followed by a direction bit (1 = read). On a match the target pulls SDA low during the ninth clock. On a mismatch it leaves SDA released and ignores all bytes until the next start.
- R3: The strap value is taken from strap_i while rst is high and held from then on. Changing strap_i after reset does not change the address the block answers to.
- R4: For HOLD_CYCLES clock cycles after reset is released, the target acknowledges nothing and never pulls SDA low.
- R5: In a write, the three bytes after the address byte load the register pointer, MSB first, and each byte is acknowledged.
- R6: Each data byte after the control byte produces a one-cycle reg_wr_en with reg_addr equal to the pointer and reg_wdata equal to the byte. The byte is acknowledged.
- R7: Control byte bit 0 = 1 advances the pointer by one after each data byte, written or read. Bit 0 = 0 keeps the pointer fixed.
- R8: A control byte whose bits 2:1 are not 00 (only one-byte width is defined) is not acknowledged. Later bytes are then ignored until the next start, and no register is written.
- R9: In a read, the target fetches the register at the pointer through a one-cycle reg_rd_en (data expected on reg_rdata in the following cycle) and shifts it out MSB first. It never asserts reg_rd_en and reg_wr_en together.
- R10: When the host does not acknowledge a read byte, the target releases SDA and waits. A repeated start keeps the pointer, so the next read continues from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; strap sampled while high |
| strap_i | input | 2 | Low two bits of the device address |
| scl_i | input | 1 | Bus clock line (asynchronous) |
| sda_i | input | 1 | Bus data line as seen on the wire (asynchronous) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_rd_en | output | 1 | One-cycle register read strobe |
| reg_addr | output | PTR_BYTES*8 | Register pointer |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data, valid the cycle after reg_rd_en |

## Verification
The assertions check on every cycle that SDA drive changes only after SCL was seen low, that a start leaves the block receiving an address with SDA released, and that nothing is driven during the startup hold. They also check that write strobes last one cycle and never coincide with read strobes. The bench scenarios cover the rest, since these depend on byte sequences: strap latching against later pin changes, the pointer and control framing, auto-increment on and off, refusal of a reserved width, and pointer retention across a NACK and a repeated start.

// File: rtl/i2c_ptr_target_pkg.sv
package i2c_ptr_target_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam logic [1:0] WIDTH_ONE_BYTE = 2'b00;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_IGNORE
  } tgt_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [1:0] scl_ff, sda_ff;
  logic       scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_p  <= scl_ff[1];
      sda_p  <= sda_ff[1];
    end
  end

  assign scl_s    = scl_ff[1];
  assign sda_s    = sda_ff[1];
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_boot_gate.sv
module i2c_boot_gate #(
  parameter int HOLD_CYCLES = 20000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] strap_i,
  output logic [1:0] strap_q,
  output logic       ready
);
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      ready   <= 1'b0;
      strap_q <= strap_i;
    end else if (!ready) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST) ready <= 1'b1;
    end
  end
endmodule

// File: rtl/i2c_xfer_core.sv
module i2c_xfer_core
  import i2c_ptr_target_pkg::*;
#(
  parameter int PTR_BYTES = 3,
  localparam int PTR_W = PTR_BYTES * BYTE_W,
  localparam int IDX_W = $clog2(PTR_BYTES + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ready,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  output logic              sda_oe,
  output logic              reg_wr_en,
  output logic              reg_rd_en,
  output logic [PTR_W-1:0]  reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  input  logic [BYTE_W-1:0] reg_rdata
);
  localparam logic [IDX_W-1:0] IDX_CTRL = IDX_W'(PTR_BYTES);
  localparam logic [IDX_W-1:0] IDX_DATA = IDX_W'(PTR_BYTES + 1);

  tgt_state_t        state;
  logic [BYTE_W-1:0] shreg, tx_buf;
  logic [3:0]        bit_cnt;
  logic [IDX_W-1:0]  byte_idx;
  logic [PTR_W-1:0]  ptr;
  logic              addr_phase, rd_mode, incr, inc_pend, rd_pipe;

  assign reg_addr = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pipe <= 1'b0;
      tx_buf  <= '0;
    end else begin
      rd_pipe <= reg_rd_en;
      if (rd_pipe) tx_buf <= reg_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      shreg      <= '0;
      bit_cnt    <= '0;
      byte_idx   <= '0;
      ptr        <= '0;
      addr_phase <= 1'b0;
      rd_mode    <= 1'b0;
      incr       <= 1'b0;
      inc_pend   <= 1'b0;
      sda_oe     <= 1'b0;
      reg_wr_en  <= 1'b0;
      reg_rd_en  <= 1'b0;
      reg_wdata  <= '0;
    end else begin
      reg_wr_en <= 1'b0;
      reg_rd_en <= 1'b0;
      if (ready && start_ev) begin
        state      <= ST_RX;
        addr_phase <= 1'b1;
        bit_cnt    <= '0;
        inc_pend   <= 1'b0;
        sda_oe     <= 1'b0;
      end else if (stop_ev) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_RX: begin
            if (scl_rise && bit_cnt < 4'd8) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 4'd1;
            end
            if (scl_fall && bit_cnt == 4'd8) begin
              if (addr_phase) begin
                if (shreg[BYTE_W-1:1] == dev_addr) begin
                  sda_oe    <= 1'b1;
                  state     <= ST_RX_ACK;
                  rd_mode   <= shreg[0];
                  byte_idx  <= '0;
                  reg_rd_en <= shreg[0];
                end else begin
                  state <= ST_IGNORE;
                end
              end else if (byte_idx < IDX_CTRL) begin
                ptr      <= (ptr << BYTE_W) | PTR_W'(shreg);
                byte_idx <= byte_idx + 1'b1;
                sda_oe   <= 1'b1;
                state    <= ST_RX_ACK;
              end else if (byte_idx == IDX_CTRL) begin
                if (shreg[2:1] == WIDTH_ONE_BYTE) begin
                  incr     <= shreg[0];
                  byte_idx <= IDX_DATA;
                  sda_oe   <= 1'b1;
                  state    <= ST_RX_ACK;
                end else begin
                  state <= ST_IGNORE;
                end
              end else begin
                reg_wr_en <= 1'b1;
                reg_wdata <= shreg;
                inc_pend  <= incr;
                sda_oe    <= 1'b1;
                state     <= ST_RX_ACK;
              end
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              addr_phase <= 1'b0;
              inc_pend   <= 1'b0;
              if (inc_pend) ptr <= ptr + 1'b1;
              if (rd_mode) begin
                state   <= ST_TX;
                shreg   <= tx_buf;
                sda_oe  <= ~tx_buf[BYTE_W-1];
                bit_cnt <= 4'd1;
              end else begin
                state   <= ST_RX;
                sda_oe  <= 1'b0;
                bit_cnt <= '0;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bit_cnt == 4'd8) begin
                sda_oe <= 1'b0;
                state  <= ST_TX_ACK;
              end else begin
                sda_oe  <= ~shreg[BYTE_W-2];
                shreg   <= shreg << 1;
                bit_cnt <= bit_cnt + 4'd1;
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              if (incr) ptr <= ptr + 1'b1;
              if (sda_s) state <= ST_IGNORE;
              else       reg_rd_en <= 1'b1;
            end
            if (scl_fall) begin
              state   <= ST_TX;
              shreg   <= tx_buf;
              sda_oe  <= ~tx_buf[BYTE_W-1];
              bit_cnt <= 4'd1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R1
  sda_change_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !$past(scl_s));

  // R1
  start_release_chk: assert property (@(posedge clk) disable iff (rst)
    (ready && start_ev) |=> (state == ST_RX) && !sda_oe);

  // R6
  wr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en |=> !reg_wr_en);

  // R9
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr_en && reg_rd_en));
endmodule

// File: rtl/i2c_ptr_target.sv
module i2c_ptr_target
  import i2c_ptr_target_pkg::*;
#(
  parameter logic [4:0] BASE_ADDR   = 5'b10011,
  parameter int         HOLD_CYCLES = 20000,
  parameter int         PTR_BYTES   = 3,
  localparam int        PTR_W       = PTR_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        strap_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic              reg_wr_en,
  output logic              reg_rd_en,
  output logic [PTR_W-1:0]  reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  input  logic [BYTE_W-1:0] reg_rdata
);
  logic       scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic [1:0] strap_q;
  logic       ready;

  i2c_line_sync u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2c_boot_gate #(.HOLD_CYCLES(HOLD_CYCLES)) u_boot (
    .clk(clk), .rst(rst), .strap_i(strap_i), .strap_q(strap_q), .ready(ready)
  );

  i2c_xfer_core #(.PTR_BYTES(PTR_BYTES)) u_core (
    .clk(clk), .rst(rst), .ready(ready), .dev_addr({BASE_ADDR, strap_q}),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .sda_oe(sda_oe),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // R4
  holdoff_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !ready |-> !sda_oe && !reg_wr_en);
endmodule

// File: tb/sim_i2c_ptr_target.sv
`timescale 1ns/1ps
module sim_i2c_ptr_target;
  localparam int HOLD = 1500;
  localparam time Q = 50ns;

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] strap = 2'b10;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, reg_wr_en, reg_rd_en;
  logic [23:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] mem [256];
  wire sda_line = m_sda & ~sda_oe;

  int n_tests = 0, n_fail = 0;
  logic [31:0] exp_wr [$];

  localparam logic [6:0] ADDR_OK  = {5'b10011, 2'b10};
  localparam logic [6:0] ADDR_BAD = {5'b10011, 2'b00};

  always #2.5 clk = ~clk;

  i2c_ptr_target #(.HOLD_CYCLES(HOLD)) u0 (
    .clk(clk), .rst(rst), .strap_i(strap), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always @(posedge clk) begin
    if (reg_wr_en) mem[reg_addr[7:0]] <= reg_wdata;
    if (reg_rd_en) reg_rdata <= mem[reg_addr[7:0]];
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops expected writes as the design produces them
  always @(negedge clk) begin
    if (!rst && reg_wr_en) begin
      if (exp_wr.size() == 0) check(1'b0, "R6 unexpected write", {reg_addr, reg_wdata}, 32'h0);
      else begin
        logic [31:0] e;
        e = exp_wr.pop_front();
        check({reg_addr, reg_wdata} == e, "R6/R7 write", {reg_addr, reg_wdata}, e);
      end
    end
  end

  task automatic bus_start();
    m_sda = 1'b1; #Q; m_scl = 1'b1; #Q; m_sda = 1'b0; #Q; m_scl = 1'b0; #Q;
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; #Q; m_scl = 1'b1; #Q; m_sda = 1'b1; #(2*Q);
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = v[i]; #Q; m_scl = 1'b1; #(2*Q); m_scl = 1'b0; #Q;
    end
  endtask

  task automatic send_byte(input logic [7:0] v, input logic exp_ack, input string req);
    logic got;
    send_bits(v, 8);
    m_sda = 1'b1; #Q; m_scl = 1'b1; #Q;
    got = ~sda_line;
    #Q; m_scl = 1'b0; #Q;
    check(got == exp_ack, req, {31'h0, got}, {31'h0, exp_ack});
  endtask

  task automatic recv_byte(input logic [7:0] exp, input logic host_ack, input string req);
    logic [7:0] v;
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      #Q; m_scl = 1'b1; #Q; v[i] = sda_line; #Q; m_scl = 1'b0; #Q;
    end
    m_sda = ~host_ack; #Q; m_scl = 1'b1; #(2*Q); m_scl = 1'b0; #Q;
    m_sda = 1'b1;
    check(v == exp, req, {24'h0, v}, {24'h0, exp});
  endtask

  task automatic write_hdr(input logic [23:0] p, input logic [7:0] ctrl, input logic ctrl_ack, input string req);
    bus_start();
    send_byte({ADDR_OK, 1'b0}, 1'b1, "R2 address ack");
    send_byte(p[23:16], 1'b1, "R5 pointer byte 2");
    send_byte(p[15:8], 1'b1, "R5 pointer byte 1");
    send_byte(p[7:0], 1'b1, "R5 pointer byte 0");
    send_byte(ctrl, ctrl_ack, req);
  endtask

  initial begin
    #(5ns * 150000);
    check(1'b0, "watchdog", 32'h0, 32'h1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    #1;
    check(sda_oe == 1'b0 && reg_wr_en == 1'b0 && reg_rd_en == 1'b0, "R4 reset state",
          {29'h0, sda_oe, reg_wr_en, reg_rd_en}, 32'h0);

    // R4: startup hold, nothing acknowledged
    bus_start();
    send_byte({ADDR_OK, 1'b0}, 1'b0, "R4 no ack during hold");
    bus_stop();
    repeat (HOLD + 200) @(posedge clk);
    strap = 2'b00;  // R3: late change must be ignored

    // R5 R6 R7: incrementing write of four bytes at 0x10
    write_hdr(24'h000010, 8'h01, 1'b1, "R5 control ack");
    exp_wr.push_back({24'h000010, 8'hA5}); send_byte(8'hA5, 1'b1, "R6 data ack");
    exp_wr.push_back({24'h000011, 8'h5A}); send_byte(8'h5A, 1'b1, "R6 data ack");
    exp_wr.push_back({24'h000012, 8'hC3}); send_byte(8'hC3, 1'b1, "R6 data ack");
    exp_wr.push_back({24'h000013, 8'h3C}); send_byte(8'h3C, 1'b1, "R6 data ack");
    bus_stop();

    // R7: fixed pointer
    write_hdr(24'h000020, 8'h00, 1'b1, "R7 control ack");
    exp_wr.push_back({24'h000020, 8'h11}); send_byte(8'h11, 1'b1, "R7 data ack");
    exp_wr.push_back({24'h000020, 8'h22}); send_byte(8'h22, 1'b1, "R7 data ack");
    bus_stop();

    // R2 R3: address built from the new strap is refused, bytes ignored
    bus_start();
    send_byte({ADDR_BAD, 1'b0}, 1'b0, "R3 strap latched at reset");
    send_byte(8'h00, 1'b0, "R2 ignored after mismatch");
    send_byte(8'h55, 1'b0, "R2 ignored after mismatch");
    bus_stop();

    // R8: reserved width refused, following data ignored
    write_hdr(24'h000030, 8'h03, 1'b0, "R8 reserved width nack");
    send_byte(8'h77, 1'b0, "R8 data ignored");
    bus_stop();

    // R9 R10: set pointer, repeated start, read with increment
    write_hdr(24'h000010, 8'h01, 1'b1, "R5 control ack");
    bus_start();
    send_byte({ADDR_OK, 1'b1}, 1'b1, "R9 read address ack");
    recv_byte(8'hA5, 1'b1, "R9 read byte 0x10");
    recv_byte(8'h5A, 1'b1, "R9 read byte 0x11");
    recv_byte(8'hC3, 1'b0, "R9 read byte 0x12");
    #Q;
    check(sda_oe == 1'b0, "R10 released after nack", {31'h0, sda_oe}, 32'h0);
    bus_start();
    send_byte({ADDR_OK, 1'b1}, 1'b1, "R10 read address ack");
    recv_byte(8'h3C, 1'b0, "R10 pointer kept across restart");
    bus_stop();

    // R7: read with fixed pointer
    write_hdr(24'h000020, 8'h00, 1'b1, "R7 control ack");
    bus_start();
    send_byte({ADDR_OK, 1'b1}, 1'b1, "R9 read address ack");
    recv_byte(8'h22, 1'b1, "R7 fixed read 1");
    recv_byte(8'h22, 1'b0, "R7 fixed read 2");
    bus_stop();

    // R1: start in the middle of a byte restarts address reception
    bus_start();
    send_byte({ADDR_OK, 1'b0}, 1'b1, "R2 address ack");
    send_bits(8'hFF, 4);
    write_hdr(24'h000040, 8'h01, 1'b1, "R1 control ack after restart");
    exp_wr.push_back({24'h000040, 8'h99}); send_byte(8'h99, 1'b1, "R1 data after restart");
    bus_stop();

    repeat (20) @(posedge clk);
    #1;
    check(exp_wr.size() == 0, "R6 all writes seen", exp_wr.size(), 32'h0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule